// File: doc/BRIEF.md
# Rule-driven link activity LED controller

This block drives three indicator LEDs from the state of a network link. For each LED, software programs a set of steady-light conditions and a set of blink conditions. The steady conditions cover link up at a given speed (10, 100, 1000 or 2500), link down, full or half duplex, and a forced-on bit. The blink conditions cover transmit or receive activity at a given speed, collisions, receive CRC errors, receive idle errors, and a forced-blink bit. Each LED also has its own enable bit and its own polarity bit.

All LEDs share one blink period and one on-time. Both are counted in ticks of an external timebase. With the reset timebase figures, 781 ticks is about 32 ms. When an LED is blinking, it is active for the on-time at the start of each period and inactive for the rest. A single-cycle activity pulse that one of an LED's blink conditions selects arms that LED. It then blinks to the end of the current period and for one more full period, so even the shortest burst gives a visible flash.

A global control register holds a rule-enable bit and a timing-clock enable bit. Clearing either one forces every LED to its inactive level. Software reaches all registers through a simple write strobe and an address/data port with combinational read-back.

Top module: `led_rule_ctrl`

## Requirements
- R1: After reset, the registers read back as follows. Control (0x21) is 0x8008. On-time (0x22) is 781. Blink period (0x23) is 1562. On-rules (0x24, 0x26, 0x28) are 0xC103, 0xC101 and 0xC102. Blink-rules (0x25, 0x27, 0x29) are 0x0000, 0x0C03 and 0x0C0C. With the link down (speed code 0), all three pins are low.
- R2: Only implemented bits can be written. On-rules keep mask 0xC17F. Blink-rules keep mask 0x0FFF. Control keeps mask 0x800F. The timing registers keep all 16 bits. Addresses outside 0x21..0x29 read 0, and writes to them have no effect.
- R3: Speed codes are 0 = down, 1 = 10, 2 = 100, 3 = 1000 and 4 = 2500. While an LED is not blinking, it is active one clock after any selected on-rule bit matches. The on-rule bits are: bit 0 link at 1000, bit 1 link at 100, bit 2 link at 10, bit 8 link at 2500, bit 3 link down, bit 4 link up and full duplex, bit 5 link up and half duplex, bit 6 always.
- R4: On-rule bit 14 set makes the pin active-high; clear makes it active-low. When on-rule bit 15 is clear, that LED is disabled and drives its inactive level.
- R5: While control bit 15 or control bit 3 is clear, every pin drives its inactive level.
- R6: A selected event pulse arms the LED. The blink-rule bits are: bits 0/1 tx/rx at 1000, bits 2/3 tx/rx at 100, bits 4/5 tx/rx at 10, bits 10/11 tx/rx at 2500 (each counts only at the current speed), bit 6 collision, bit 7 CRC error, bit 8 idle error. Once armed, the LED blinks for the rest of the current period and one further full period, then returns to its on-rules. An event whose blink-rule bit is clear has no effect.
- R7: While blinking, the pin is active exactly when the shared phase is below the on-time. The phase counts 0 to period-1 and then wraps. Blink-rule bit 9 forces continuous blinking.
- R8: The phase advances only on cycles with the tick input high.
- R9: A write to the blink-period register restarts the phase at 0. The first on-time samples after the write are therefore active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick, one cycle wide |
| link_speed | input | 3 | Speed code: 0 down, 1 10, 2 100, 3 1000, 4 2500 |
| link_full_dup | input | 1 | 1 = full duplex |
| ev_tx | input | 1 | Transmit activity pulse |
| ev_rx | input | 1 | Receive activity pulse |
| ev_col | input | 1 | Collision pulse |
| ev_crc | input | 1 | Receive CRC error pulse |
| ev_idle | input | 1 | Receive idle error pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| led_pin | output | 3 | LED pins, polarity applied |

## Verification
The bound checker watches the timing counter on every cycle. It checks that the phase holds without a tick, returns to zero after a period write and stays below a nonzero period. On every cycle it also checks that gating or disabling drives the inactive level and that a selected event arms the LED. Only the bench scenarios can show the visible results. These are the full mapping from link state to steady light, the exact active window of each blink period across several period and on-time pairs, the length of a blink burst after a single pulse, and that events the rules do not select leave the pins unchanged.

// File: rtl/led_rule_pkg.sv
package led_rule_pkg;
  localparam int REG_W = 16;

  typedef enum logic [2:0] {
    SPD_DOWN = 3'd0,
    SPD_10   = 3'd1,
    SPD_100  = 3'd2,
    SPD_1000 = 3'd3,
    SPD_2500 = 3'd4
  } speed_e;

  localparam int ADR_CTRL  = 'h21;
  localparam int ADR_ONT   = 'h22;
  localparam int ADR_PER   = 'h23;
  localparam int ADR_ON0   = 'h24;
  localparam int ADR_BLK0  = 'h25;

  localparam logic [REG_W-1:0] MASK_ON   = 16'hC17F;
  localparam logic [REG_W-1:0] MASK_BLK  = 16'h0FFF;
  localparam logic [REG_W-1:0] MASK_CTRL = 16'h800F;
  localparam logic [REG_W-1:0] CTRL_RST  = 16'h8008;

  function automatic logic [REG_W-1:0] on_reset(input int idx);
    case (idx)
      0:       return 16'hC103;
      1:       return 16'hC101;
      2:       return 16'hC102;
      default: return 16'hC000;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] blink_reset(input int idx);
    case (idx)
      1:       return 16'h0C03;
      2:       return 16'h0C0C;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_rule_pkg::*;
#(
  parameter int NLED     = 3,
  parameter int AW       = 6,
  parameter int DUR_UNIT = 781
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [REG_W-1:0]            wdata,
  output logic [REG_W-1:0]            rdata,
  output logic [REG_W-1:0]            ctrl,
  output logic [REG_W-1:0]            on_time,
  output logic [REG_W-1:0]            period,
  output logic [NLED-1:0][REG_W-1:0]  on_rule,
  output logic [NLED-1:0][REG_W-1:0]  blink_rule,
  output logic                        per_wr
);
  localparam logic [REG_W-1:0] ONT_RST = REG_W'(DUR_UNIT);
  localparam logic [REG_W-1:0] PER_RST = REG_W'(DUR_UNIT << 1);

  logic [REG_W-1:0]           ctrl_n, ont_n, per_n;
  logic [NLED-1:0][REG_W-1:0] on_n, blk_n;

  always_comb begin
    ctrl_n = ctrl;
    ont_n  = on_time;
    per_n  = period;
    on_n   = on_rule;
    blk_n  = blink_rule;
    per_wr = 1'b0;
    if (we) begin
      if (addr == AW'(ADR_CTRL)) ctrl_n = wdata & MASK_CTRL;
      if (addr == AW'(ADR_ONT))  ont_n  = wdata;
      if (addr == AW'(ADR_PER)) begin
        per_n  = wdata;
        per_wr = 1'b1;
      end
      for (int i = 0; i < NLED; i++) begin
        if (addr == AW'(ADR_ON0 + 2*i))  on_n[i]  = wdata & MASK_ON;
        if (addr == AW'(ADR_BLK0 + 2*i)) blk_n[i] = wdata & MASK_BLK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RST;
      on_time <= ONT_RST;
      period  <= PER_RST;
      for (int i = 0; i < NLED; i++) begin
        on_rule[i]    <= on_reset(i);
        blink_rule[i] <= blink_reset(i);
      end
    end else begin
      ctrl       <= ctrl_n;
      on_time    <= ont_n;
      period     <= per_n;
      on_rule    <= on_n;
      blink_rule <= blk_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(ADR_CTRL)) rdata = ctrl;
    if (addr == AW'(ADR_ONT))  rdata = on_time;
    if (addr == AW'(ADR_PER))  rdata = period;
    for (int i = 0; i < NLED; i++) begin
      if (addr == AW'(ADR_ON0 + 2*i))  rdata = on_rule[i];
      if (addr == AW'(ADR_BLK0 + 2*i)) rdata = blink_rule[i];
    end
  end
endmodule

// File: rtl/led_phase.sv
module led_phase
  import led_rule_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [REG_W-1:0] period,
  output logic [REG_W-1:0] phase,
  output logic             wrap
);
  logic [REG_W-1:0] phase_n;
  logic [REG_W:0]   next_cnt;

  always_comb begin
    next_cnt = {1'b0, phase} + 1'b1;
    wrap     = tick && !restart && (next_cnt >= {1'b0, period});
    phase_n  = phase;
    if (restart)   phase_n = '0;
    else if (wrap) phase_n = '0;
    else if (tick) phase_n = next_cnt[REG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_n;
  end
endmodule

// File: rtl/led_lane.sv
module led_lane
  import led_rule_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] on_rule,
  input  logic [REG_W-1:0] blink_rule,
  input  logic [2:0]       speed,
  input  logic             full_dup,
  input  logic             ev_tx,
  input  logic             ev_rx,
  input  logic             ev_col,
  input  logic             ev_crc,
  input  logic             ev_idle,
  input  logic             wrap,
  input  logic [REG_W-1:0] phase,
  input  logic [REG_W-1:0] on_time,
  input  logic             global_en,
  output logic             pin,
  output logic [1:0]       pend,
  output logic             hit
);
  logic       link_up, on_match, tx_sel, rx_sel, blinking, act, pin_n;
  logic [1:0] pend_n;

  always_comb begin
    link_up  = (speed != SPD_DOWN);
    on_match = (on_rule[0] && speed == SPD_1000) ||
               (on_rule[1] && speed == SPD_100)  ||
               (on_rule[2] && speed == SPD_10)   ||
               (on_rule[8] && speed == SPD_2500) ||
               (on_rule[3] && !link_up)          ||
               (on_rule[4] && link_up && full_dup)  ||
               (on_rule[5] && link_up && !full_dup) ||
               on_rule[6];
    case (speed)
      SPD_1000: begin tx_sel = blink_rule[0];  rx_sel = blink_rule[1];  end
      SPD_100:  begin tx_sel = blink_rule[2];  rx_sel = blink_rule[3];  end
      SPD_10:   begin tx_sel = blink_rule[4];  rx_sel = blink_rule[5];  end
      SPD_2500: begin tx_sel = blink_rule[10]; rx_sel = blink_rule[11]; end
      default:  begin tx_sel = 1'b0;           rx_sel = 1'b0;           end
    endcase
    hit = (ev_tx && tx_sel) || (ev_rx && rx_sel) ||
          (ev_col && blink_rule[6]) || (ev_crc && blink_rule[7]) ||
          (ev_idle && blink_rule[8]);
    pend_n = pend;
    if (hit)                       pend_n = 2'd2;
    else if (wrap && pend != 2'd0) pend_n = pend - 2'd1;
    blinking = (pend != 2'd0) || blink_rule[9];
    act      = global_en && on_rule[15] &&
               (blinking ? (phase < on_time) : on_match);
    pin_n    = on_rule[14] ? act : !act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 2'd0;
      pin  <= 1'b0;
    end else begin
      pend <= pend_n;
      pin  <= pin_n;
    end
  end
endmodule

// File: rtl/led_rule_ctrl.sv
module led_rule_ctrl
  import led_rule_pkg::*;
#(
  parameter int NLED     = 3,
  parameter int AW       = 6,
  parameter int DUR_UNIT = 781
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [2:0]       link_speed,
  input  logic             link_full_dup,
  input  logic             ev_tx,
  input  logic             ev_rx,
  input  logic             ev_col,
  input  logic             ev_crc,
  input  logic             ev_idle,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [NLED-1:0]  led_pin
);
  logic [REG_W-1:0]           ctrl_q, ont_q, period_q, phase_q;
  logic [NLED-1:0][REG_W-1:0] on_rule_q, blink_rule_q;
  logic                       per_wr, wrap, global_en;
  logic [NLED-1:0][1:0]       lane_pend;
  logic [NLED-1:0]            lane_hit;

  led_regs #(.NLED(NLED), .AW(AW), .DUR_UNIT(DUR_UNIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl_q),
    .on_time(ont_q), .period(period_q), .on_rule(on_rule_q),
    .blink_rule(blink_rule_q), .per_wr(per_wr)
  );

  led_phase u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(per_wr),
    .period(period_q), .phase(phase_q), .wrap(wrap)
  );

  assign global_en = ctrl_q[15] && ctrl_q[3];

  for (genvar i = 0; i < NLED; i++) begin : g_lane
    led_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .on_rule(on_rule_q[i]), .blink_rule(blink_rule_q[i]),
      .speed(link_speed), .full_dup(link_full_dup),
      .ev_tx(ev_tx), .ev_rx(ev_rx), .ev_col(ev_col),
      .ev_crc(ev_crc), .ev_idle(ev_idle),
      .wrap(wrap), .phase(phase_q), .on_time(ont_q),
      .global_en(global_en),
      .pin(led_pin[i]), .pend(lane_pend[i]), .hit(lane_hit[i])
    );
  end
endmodule

// File: rtl/led_rule_chk.sv
module led_rule_chk
  import led_rule_pkg::*;
#(
  parameter int NLED = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       per_wr,
  input logic [REG_W-1:0]           phase,
  input logic [REG_W-1:0]           period,
  input logic [REG_W-1:0]           ctrl,
  input logic [NLED-1:0][REG_W-1:0] on_rule,
  input logic [NLED-1:0]            pin,
  input logic [NLED-1:0][1:0]       pend,
  input logic [NLED-1:0]            hit
);
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !per_wr) |=> $stable(phase));

  a_r9_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    per_wr |=> (phase == '0));

  a_r7_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (period != '0) |-> (phase < period));

  for (genvar i = 0; i < NLED; i++) begin : g_chk
    a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl[15] && ctrl[3]) |=> (pin[i] == !$past(on_rule[i][14])));

    a_r4_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !on_rule[i][15] |=> (pin[i] == !$past(on_rule[i][14])));

    a_r6_event_arms: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> (pend[i] == 2'd2));
  end
endmodule

bind led_rule_ctrl led_rule_chk #(.NLED(NLED)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .per_wr(per_wr),
  .phase(phase_q), .period(period_q), .ctrl(ctrl_q),
  .on_rule(on_rule_q), .pin(led_pin), .pend(lane_pend), .hit(lane_hit)
);

// File: tb/led_rule_ctrl_test.sv
module led_rule_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n, tick, full_dup;
  logic [2:0]  speed;
  logic        ev_tx, ev_rx, ev_col, ev_crc, ev_idle;
  logic        we;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;
  logic [2:0]  pin;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  led_rule_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .link_speed(speed),
    .link_full_dup(full_dup), .ev_tx(ev_tx), .ev_rx(ev_rx),
    .ev_col(ev_col), .ev_crc(ev_crc), .ev_idle(ev_idle),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .led_pin(pin)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [15:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  function automatic bit on_expect(input int b, input int spd, input bit fd);
    bit up = (spd != 0);
    case (b)
      0: return spd == 3;
      1: return spd == 2;
      2: return spd == 1;
      8: return spd == 4;
      3: return !up;
      4: return up && fd;
      5: return up && !fd;
      6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int bits[8] = '{0, 1, 2, 3, 4, 5, 6, 8};
    int pers[6] = '{6, 5, 4, 7, 1, 3};
    int onts[6] = '{2, 0, 4, 3, 1, 5};
    rst_n = 1'b0; tick = 1'b1; speed = 3'd0; full_dup = 1'b1;
    ev_tx = 0; ev_rx = 0; ev_col = 0; ev_crc = 0; ev_idle = 0;
    we = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset values and pins
    check("R1 pins", pin, 3'b000);
    rd_chk("R1 ctrl", 6'h21, 16'h8008);
    rd_chk("R1 ontime", 6'h22, 16'd781);
    rd_chk("R1 period", 6'h23, 16'd1562);
    rd_chk("R1 on0", 6'h24, 16'hC103);
    rd_chk("R1 blk0", 6'h25, 16'h0000);
    rd_chk("R1 on1", 6'h26, 16'hC101);
    rd_chk("R1 blk1", 6'h27, 16'h0C03);
    rd_chk("R1 on2", 6'h28, 16'hC102);
    rd_chk("R1 blk2", 6'h29, 16'h0C0C);
    @(negedge clk);

    // R2 write masks and unmapped addresses
    wr(6'h24, 16'hFFFF); rd_chk("R2 on mask", 6'h24, 16'hC17F);
    @(negedge clk);
    wr(6'h29, 16'hFFFF); rd_chk("R2 blink mask", 6'h29, 16'h0FFF);
    @(negedge clk);
    wr(6'h21, 16'hFFFF); rd_chk("R2 ctrl mask", 6'h21, 16'h800F);
    @(negedge clk);
    wr(6'h22, 16'hFFFF); rd_chk("R2 ontime full", 6'h22, 16'hFFFF);
    @(negedge clk);
    wr(6'h30, 16'hFFFF); rd_chk("R2 unmapped", 6'h30, 16'h0000);
    rd_chk("R2 unmapped write no effect", 6'h26, 16'hC101);
    @(negedge clk);
    wr(6'h21, 16'h8008);
    wr(6'h25, 16'h0); wr(6'h27, 16'h0); wr(6'h29, 16'h0);

    // R3 / R4 sweep: LED0 active high, LED1 disabled, LED2 active low
    foreach (bits[k]) begin
      wr(6'h24, 16'hC000 | (16'd1 << bits[k]));
      wr(6'h26, 16'h4000 | (16'd1 << bits[k]));
      wr(6'h28, 16'h8000 | (16'd1 << bits[k]));
      for (int s = 0; s < 5; s++) begin
        for (int f = 0; f < 2; f++) begin
          bit m;
          speed = 3'(s); full_dup = f[0];
          repeat (2) @(negedge clk);
          m = on_expect(bits[k], s, f[0]);
          check("R3 on-rule match", pin[0], m);
          check("R4 disabled inactive", pin[1], 1'b0);
          check("R4 active low", pin[2], !m);
        end
      end
    end

    // R5 global gating
    wr(6'h24, 16'hC040); wr(6'h26, 16'hC040); wr(6'h28, 16'h8040);
    @(negedge clk);
    check("R5 enabled force on", pin, 3'b011);
    wr(6'h21, 16'h0008); @(negedge clk);
    check("R5 rule-enable clear", pin, 3'b100);
    wr(6'h21, 16'h8000); @(negedge clk);
    check("R5 clock-enable clear", pin, 3'b100);
    wr(6'h21, 16'h8008); @(negedge clk);
    check("R5 restored", pin, 3'b011);

    // R7 / R9 forced blink window sweep on LED0
    wr(6'h24, 16'hC000); wr(6'h26, 16'h4000); wr(6'h28, 16'h0000);
    wr(6'h25, 16'h0200);
    foreach (pers[p]) begin
      wr(6'h22, 16'(onts[p]));
      wr(6'h23, 16'(pers[p]));
      for (int j = 0; j < 4*pers[p]; j++) begin
        @(negedge clk);
        if (j < onts[p]) check("R9 restart window", pin[0], 1'b1);
        else check("R7 blink window", pin[0], ((j % pers[p]) < onts[p]));
      end
    end

    // R8 no tick: phase stays 0
    tick = 1'b0;
    wr(6'h22, 16'd3); wr(6'h23, 16'd6);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk); check("R8 held in window", pin[0], 1'b1);
    end
    wr(6'h22, 16'd0);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk); check("R8 held zero on-time", pin[0], 1'b0);
    end
    tick = 1'b1;
    wr(6'h25, 16'h0000);

    // R6 event-driven blink on LED1
    wr(6'h24, 16'h4000); wr(6'h26, 16'hC000); wr(6'h27, 16'h0001);
    wr(6'h22, 16'd2);
    speed = 3'd3;
    repeat (12) @(negedge clk);
    check("R6 idle before event", pin[1], 1'b0);
    we = 1; addr = 6'h23; wdata = 16'd5; ev_tx = 1;
    @(negedge clk);
    we = 0; ev_tx = 0;
    for (int j = 0; j < 15; j++) begin
      @(negedge clk);
      check("R6 tx burst", pin[1], (j < 10) ? ((j % 5) < 2) : 1'b0);
    end
    ev_rx = 1; @(negedge clk); ev_rx = 0;
    for (int j = 0; j < 15; j++) begin
      @(negedge clk); check("R6 unselected rx ignored", pin[1], 1'b0);
    end
    speed = 3'd2;
    ev_tx = 1; @(negedge clk); ev_tx = 0;
    for (int j = 0; j < 15; j++) begin
      @(negedge clk); check("R6 wrong speed ignored", pin[1], 1'b0);
    end
    wr(6'h27, 16'h0040);
    speed = 3'd0;
    we = 1; addr = 6'h23; wdata = 16'd5; ev_col = 1;
    @(negedge clk);
    we = 0; ev_col = 0;
    for (int j = 0; j < 15; j++) begin
      @(negedge clk);
      check("R6 collision burst", pin[1], (j < 10) ? ((j % 5) < 2) : 1'b0);
    end

    finish_run();
  end
endmodule